// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that sits behind a small 16-bit register interface. Software programs a timeout in half-second units and sets an enable bit. From then on the timer cannot be stopped. Software must keep it alive with a two-write key handshake on a service register. If the countdown runs out, the block emits a one-cycle timeout pulse. It also asserts a reset request when reset generation is allowed, and it latches a flag. That flag survives an ordinary system reset, so the restarted software can tell that the watchdog caused the restart.

The countdown does not run on the bus clock. It moves on a slow time-base pulse, `tick`, in which each pulse stands for half a second. When the one-time low-power suspend option has been chosen, a low-power indication from the system freezes the countdown. There are two reset inputs. The power-on reset clears everything. The system reset clears everything except the timeout-cause flag.

Top module: `svc_watchdog`

## Requirements
- R1: After power-on reset every register reads zero (control at offset 0x0, status at offset 0x4), and `tmo_pulse` and `wd_rst_req` are low.
- R2: With timeout field N (control bits 15:8), the counter expires on the (N+1)-th counted tick after it was last loaded. Expiry is seen as `tmo_pulse` high in the cycle after that tick's clock edge, and this holds for every N from 0 to 255.
- R3: Writing 0x5555 to the service register (offset 0x2) and then 0xAAAA as the next service write reloads the counter with the current timeout field.
- R4: A service write of any value other than 0xAAAA after 0x5555 returns the key checker to idle without a reload. A lone 0xAAAA never reloads. A write of 0x5555 always arms the checker.
- R5: The enable bit (control bit 2) is sticky. Writing it as 0 while it is set has no effect, and the timer keeps running.
- R6: The suspend bit (control bit 0) is captured only by the first control write after reset, and later control writes leave it unchanged.
- R7: While the `low_power` input is high and the suspend bit is set, ticks are not counted.
- R8: A new timeout value written while the timer runs does not change the count in progress. It is used at the next service reload.
- R9: On expiry `wd_rst_req` goes high if reset-enable (control bit 3) is set, and it stays high until a reset. With reset-enable clear it stays low.
- R10: Expiry sets status bit 1 (status reads 0x0002). A system reset keeps it, and only power-on reset clears it.
- R11: When a completing 0xAAAA service write and the tick that would expire the counter fall in the same cycle, the reload wins and no timeout occurs.
- R12: `tmo_pulse` is a single-cycle pulse.
- R13: While disabled, ticks cause no timeout. Setting the enable bit loads the counter from the timeout field written with it, so the first period starts at enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | System reset, synchronous, active high, keeps the timeout-cause flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for the offset presented in the previous cycle |
| tick | input | 1 | Half-second time-base pulse |
| low_power | input | 1 | Low-power mode indication |
| tmo_pulse | output | 1 | One-cycle timeout indication |
| wd_rst_req | output | 1 | Latched reset request to the reset controller |

## Verification
The clash that matters most here is a service reload meeting an expiring tick. The closing 0xAAAA write is issued in the same cycle as the tick that finds the counter at zero. The bench judges that no pulse appears and that a full new period of N+1 ticks is then needed. A second overlap is a timeout-field rewrite during a running count. The bench checks that the count in progress finishes on the old value and that the following reload takes the new one.

// File: rtl/svc_watchdog_pkg.sv
package svc_watchdog_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'h0;
  localparam logic [ADDR_W-1:0] OFF_SVC  = 3'h2;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'h4;
  localparam int CB_SUSP   = 0;
  localparam int CB_EN     = 2;
  localparam int CB_RSTEN  = 3;
  localparam int CB_TO_LSB = 8;
  localparam int SB_TMO    = 1;
  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;
  typedef enum logic {KS_IDLE, KS_ARMED} ks_state_t;
endpackage

// File: rtl/wd_regs.sv
module wd_regs
  import svc_watchdog_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              expire,
  output logic [TO_W-1:0]   to_val,
  output logic              rst_en,
  output logic              en,
  output logic              susp,
  output logic              susp_lock,
  output logic              en_load,
  output logic              status,
  output logic              wr_svc,
  output logic [REG_W-1:0]  rdata
);
  logic wr_ctrl;
  logic [REG_W-1:0] ctrl_word;
  logic [REG_W-1:0] stat_word;

  assign wr_ctrl = wr_en && (addr == OFF_CTRL);
  assign wr_svc  = wr_en && (addr == OFF_SVC);
  assign en_load = wr_ctrl && wdata[CB_EN] && !en;

  always_ff @(posedge clk) begin
    if (por || rst) begin
      to_val    <= '0;
      rst_en    <= 1'b0;
      en        <= 1'b0;
      susp      <= 1'b0;
      susp_lock <= 1'b0;
    end else if (wr_ctrl) begin
      to_val <= wdata[CB_TO_LSB +: TO_W];
      rst_en <= wdata[CB_RSTEN];
      en     <= en | wdata[CB_EN];
      if (!susp_lock) begin
        susp      <= wdata[CB_SUSP];
        susp_lock <= 1'b1;
      end
    end
  end

  // cause flag: only power-on clears it
  always_ff @(posedge clk) begin
    if (por) status <= 1'b0;
    else if (expire) status <= 1'b1;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_TO_LSB +: TO_W] = to_val;
    ctrl_word[CB_RSTEN] = rst_en;
    ctrl_word[CB_EN]    = en;
    ctrl_word[CB_SUSP]  = susp;
    stat_word = '0;
    stat_word[SB_TMO] = status;
  end

  always_ff @(posedge clk) begin
    if (por || rst) rdata <= '0;
    else begin
      case (addr)
        OFF_CTRL: rdata <= ctrl_word;
        OFF_STAT: rdata <= stat_word;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wd_keyseq.sv
module wd_keyseq
  import svc_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_svc,
  input  logic [REG_W-1:0] wdata,
  output logic             reload
);
  ks_state_t state;

  assign reload = wr_svc && (state == KS_ARMED) && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (clr) state <= KS_IDLE;
    else if (wr_svc) state <= (wdata == KEY_FIRST) ? KS_ARMED : KS_IDLE;
  end
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            en,
  input  logic            load,
  input  logic [TO_W-1:0] load_val,
  input  logic            reload,
  input  logic [TO_W-1:0] reload_val,
  input  logic            tick,
  input  logic            freeze,
  output logic            expire,
  output logic            tmo_pulse,
  output logic [TO_W-1:0] cnt
);
  logic step;

  assign step   = en && tick && !freeze;
  assign expire = step && (cnt == '0) && !reload && !load;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt       <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= expire;
      if (load)        cnt <= load_val;
      else if (reload) cnt <= reload_val;
      else if (expire) cnt <= reload_val;
      else if (step)   cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_watchdog_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tick,
  input  logic              low_power,
  output logic              tmo_pulse,
  output logic              wd_rst_req
);
  logic            clr;
  logic [TO_W-1:0] to_val;
  logic            rst_en, en, susp, susp_lock, en_load, status, wr_svc;
  logic            reload, expire, freeze;
  logic [TO_W-1:0] cnt;

  assign clr    = por | rst;
  assign freeze = low_power & susp;

  wd_regs #(.TO_W(TO_W)) u_regs (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .expire(expire), .to_val(to_val), .rst_en(rst_en),
    .en(en), .susp(susp), .susp_lock(susp_lock), .en_load(en_load),
    .status(status), .wr_svc(wr_svc), .rdata(rdata)
  );

  wd_keyseq u_keys (
    .clk(clk), .clr(clr), .wr_svc(wr_svc), .wdata(wdata), .reload(reload)
  );

  wd_counter #(.TO_W(TO_W)) u_cnt (
    .clk(clk), .clr(clr), .en(en), .load(en_load),
    .load_val(wdata[CB_TO_LSB +: TO_W]), .reload(reload),
    .reload_val(to_val), .tick(tick), .freeze(freeze), .expire(expire),
    .tmo_pulse(tmo_pulse), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (clr) wd_rst_req <= 1'b0;
    else if (expire && rst_en) wd_rst_req <= 1'b1;
  end
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            por,
  input logic            rst,
  input logic            tmo_pulse,
  input logic            wd_rst_req,
  input logic            en,
  input logic            susp,
  input logic            susp_lock,
  input logic            status,
  input logic            freeze,
  input logic            reload,
  input logic            en_load,
  input logic [TO_W-1:0] cnt
);
  AST_RSTREQ_HOLDS: assert property (@(posedge clk) disable iff (por || rst)
    wd_rst_req |=> wd_rst_req); // R9
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (por || rst)
    en |=> en); // R5
  AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (por || rst)
    susp_lock |=> $stable(susp)); // R6
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (por || rst)
    (freeze && !reload && !en_load) |=> $stable(cnt)); // R7
  AST_STATUS_ON_TMO: assert property (@(posedge clk) disable iff (por)
    tmo_pulse |-> status); // R10
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (por || rst)
    !en |=> !tmo_pulse); // R13
  AST_TMO_AT_ZERO: assert property (@(posedge clk) disable iff (por || rst)
    tmo_pulse |-> ($past(cnt) == '0)); // R2
endmodule

bind svc_watchdog svc_watchdog_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .por(por), .rst(rst), .tmo_pulse(tmo_pulse),
  .wd_rst_req(wd_rst_req), .en(en), .susp(susp), .susp_lock(susp_lock),
  .status(status), .freeze(freeze), .reload(reload), .en_load(en_load),
  .cnt(cnt)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
  logic clk = 1'b0;
  logic por = 1'b0, rst = 1'b0, wr_en = 1'b0, tick = 1'b0, low_power = 1'b0;
  logic [2:0] addr = 3'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic tmo_pulse, wd_rst_req;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  svc_watchdog u_svc_watchdog (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .low_power(low_power),
    .tmo_pulse(tmo_pulse), .wd_rst_req(wd_rst_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por = 1'b1; @(negedge clk); por = 1'b0;
  endtask
  task automatic do_rst();
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; @(negedge clk); d = rdata;
  endtask
  // one tick; returns tmo_pulse seen after its edge
  task automatic tk(output logic p);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; p = tmo_pulse;
  endtask
  task automatic ticks(input int n, output logic any);
    logic p;
    any = 1'b0;
    for (int i = 0; i < n; i++) begin tk(p); any |= p; end
  endtask

  initial begin
    logic [15:0] d;
    logic p, any;
    do_por();
    // R1
    rd(3'h0, d); check("R1 ctrl", d, 16'h0);
    rd(3'h4, d); check("R1 status", d, 16'h0);
    check("R1 outputs", {14'h0, tmo_pulse, wd_rst_req}, 16'h0);

    // R2 sweep, R12 width, R9 low when reset-enable clear
    for (int n = 0; n < 9; n++) begin
      int nv = (n == 8) ? 255 : n;
      do_rst();
      wr(3'h0, {nv[7:0], 8'h04}, 1'b0);
      ticks(nv, any); check("R2 early", {15'h0, any}, 16'h0);
      tk(p); check("R2 expiry", {15'h0, p}, 16'h1);
      @(negedge clk); check("R12 width", {15'h0, tmo_pulse}, 16'h0);
      check("R9 no req", {15'h0, wd_rst_req}, 16'h0);
    end

    // R10 status kept across rst, cleared by por
    rd(3'h4, d); check("R10 set", d, 16'h0002);
    do_rst(); rd(3'h4, d); check("R10 kept", d, 16'h0002);
    do_por(); rd(3'h4, d); check("R10 por", d, 16'h0);

    // R13 disabled then enable loads
    wr(3'h0, 16'h0200, 1'b0);
    ticks(10, any); check("R13 disabled", {15'h0, any}, 16'h0);
    wr(3'h0, 16'h0204, 1'b0);
    ticks(2, any); check("R13 early", {15'h0, any}, 16'h0);
    tk(p); check("R13 first period", {15'h0, p}, 16'h1);

    // R3 reload
    do_rst(); wr(3'h0, 16'h0304, 1'b0);
    ticks(3, any);
    wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'hAAAA, 1'b0);
    ticks(3, any); check("R3 reloaded", {15'h0, any}, 16'h0);
    tk(p); check("R3 expiry", {15'h0, p}, 16'h1);

    // R4 broken sequences
    do_rst(); wr(3'h0, 16'h0304, 1'b0);
    ticks(3, any);
    wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'h1234, 1'b0); wr(3'h2, 16'hAAAA, 1'b0);
    wr(3'h2, 16'hAAAA, 1'b0);
    tk(p); check("R4 no reload", {15'h0, p}, 16'h1);
    wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'hAAAA, 1'b0);
    ticks(3, any); tk(p);
    check("R4 rearm", {14'h0, any, p}, 16'h1);

    // R5 sticky enable
    do_rst(); wr(3'h0, 16'h0304, 1'b0); wr(3'h0, 16'h0300, 1'b0);
    rd(3'h0, d); check("R5 readback", d, 16'h0304);
    ticks(3, any); tk(p); check("R5 still runs", {14'h0, any, p}, 16'h1);

    // R6/R7 suspend set first
    do_rst(); wr(3'h0, 16'h0305, 1'b0); wr(3'h0, 16'h0304, 1'b0);
    rd(3'h0, d); check("R6 kept set", d, 16'h0305);
    low_power = 1'b1;
    ticks(10, any); check("R7 frozen", {15'h0, any}, 16'h0);
    low_power = 1'b0;
    ticks(3, any); tk(p); check("R7 resumes", {14'h0, any, p}, 16'h1);
    // suspend clear first, later set ignored
    do_rst(); wr(3'h0, 16'h0304, 1'b0); wr(3'h0, 16'h0305, 1'b0);
    rd(3'h0, d); check("R6 kept clear", d, 16'h0304);
    low_power = 1'b1;
    ticks(3, any); tk(p); check("R6 not frozen", {14'h0, any, p}, 16'h1);
    low_power = 1'b0;

    // R8 timeout change applies at reload
    do_rst(); wr(3'h0, 16'h0504, 1'b0);
    ticks(2, any); wr(3'h0, 16'h0104, 1'b0);
    rd(3'h0, d); check("R8 readback", d, 16'h0104);
    ticks(3, any); check("R8 old count", {15'h0, any}, 16'h0);
    wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'hAAAA, 1'b0);
    tk(p); check("R8 new early", {15'h0, p}, 16'h0);
    tk(p); check("R8 new expiry", {15'h0, p}, 16'h1);

    // R9 reset request
    do_rst(); wr(3'h0, 16'h020C, 1'b0);
    ticks(3, any); check("R9 req", {15'h0, wd_rst_req}, 16'h1);
    repeat (5) @(negedge clk);
    check("R9 held", {15'h0, wd_rst_req}, 16'h1);
    do_rst(); check("R9 cleared", {15'h0, wd_rst_req}, 16'h0);

    // R11 reload and expiring tick together
    wr(3'h0, 16'h0204, 1'b0);
    ticks(2, any);
    wr(3'h2, 16'h5555, 1'b0); wr(3'h2, 16'hAAAA, 1'b1);
    check("R11 no pulse", {15'h0, tmo_pulse}, 16'h0);
    ticks(2, any); tk(p); check("R11 full period", {14'h0, any, p}, 16'h1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule